// File: doc/BRIEF.md
# Serial NOR Flash Erase Sequencer

This block runs one complete erase of a serial NOR flash without software help between its steps. It takes a single start pulse, an erase kind (whole chip, block or sector) and a 24-bit byte address. It then drives an external SPI byte shifter through three kinds of framed transaction. The first is the write-enable command. The second is the erase command, which carries the address for block and sector kinds. The third is the read-status command, repeated until the device reports that its internal write cycle has finished.

Each status read waits a programmable number of clock cycles before it starts. The wait depends on the erase kind, because a chip erase takes far longer than a sector erase, and a longer wait saves bus traffic. A poll limit bounds the whole operation. If the device is still busy after that many reads, the block finishes and raises an error flag.

The command side has plain control pins with no back-pressure: a start pulse that arrives while the block is busy is dropped. Flow control toward the shifter is a one-byte-at-a-time handshake. The sequencer pulses a start with the byte to send and waits for the shifter's done pulse, which returns the byte clocked in. Chip select framing belongs to the sequencer.

Top module: `spi_erase_seq`

## Requirements
- R1: After reset, busy, done and err are 0, spi_cs_n is 1 and spi_start is 0.
- R2: A cmd_start pulse while idle is accepted and raises busy on the next cycle when cmd_op is 0 (chip), 1 (block) or 2 (sector). Code 3 is ignored: busy stays 0 and chip select stays high.
- R3: The first transaction of every operation holds exactly one byte, 0x06.
- R4: The second transaction carries the erase command. For chip erase it is the single byte 0xC7. Block erase sends 0xD8 and sector erase sends 0x20, each followed by the three address bytes, bits 23:16 first and bits 7:0 last.
- R5: spi_cs_n goes high after the last byte of each transaction and stays high for exactly one cycle between the write-enable and erase transactions.
- R6: Each status transaction sends 0x05, then a filler byte 0x00. Bit 0 of the byte received for the filler is the write-in-progress flag, and bits 7:1 have no effect.
- R7: Before every status transaction, spi_cs_n stays high for exactly WAIT_CHIP, WAIT_BLOCK or WAIT_SECTOR cycles, chosen by the erase kind.
- R8: Status reads repeat while the flag reads 1. The first read of 0 ends the operation: done pulses for one cycle, busy is 0 in that cycle and err is 0.
- R9: If MAX_POLLS consecutive reads all return 1, the operation ends with done and err=1, after exactly MAX_POLLS status transactions. err then holds until the next accepted start clears it.
- R10: A cmd_start pulse while busy has no effect: the transaction bytes and their count follow the operation already in progress.
- R11: spi_start is a one-cycle pulse, given only while spi_cs_n is low. At most one byte is outstanding until spi_done returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Start pulse for one erase operation |
| cmd_op | input | 2 | Erase kind: 0 chip, 1 block, 2 sector, 3 reserved |
| cmd_addr | input | 24 | Byte address for block and sector erase |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse when the operation ends |
| err | output | 1 | Poll limit reached; held until the next accepted start |
| spi_cs_n | output | 1 | Active-low chip select for the flash |
| spi_start | output | 1 | Request to shift one byte |
| spi_tx | output | 8 | Byte to send, valid with spi_start |
| spi_done | input | 1 | Shifter finished the requested byte |
| spi_rx | input | 8 | Byte received, valid with spi_done |

## Verification
The assertions check the handshake rules on every cycle. These are: a shifter start only inside a chip-select frame, as a single pulse; chip select releasing only after a shifter done; done arriving with busy low; err rising only with done and falling only at an accepted start; and a reserved code never raising busy. Only the bench scenarios can show the byte content and order of each transaction, the exact chip-select gaps for each erase kind, and the number of status reads for a given device busy time. Those scenarios also cover the poll-limit boundary and the dropping of a second start in mid-operation.

// File: rtl/spi_erase_pkg.sv
package spi_erase_pkg;

  localparam int ADDR_W = 24;

  typedef enum logic [1:0] {
    OP_CHIP   = 2'd0,
    OP_BLOCK  = 2'd1,
    OP_SECTOR = 2'd2,
    OP_RSVD   = 2'd3
  } erase_op_e;

  typedef enum logic [1:0] {
    TX_WREN  = 2'd0,
    TX_ERASE = 2'd1,
    TX_POLL  = 2'd2
  } txn_e;

  localparam logic [7:0] OPC_WREN   = 8'h06;
  localparam logic [7:0] OPC_CHIP   = 8'hC7;
  localparam logic [7:0] OPC_BLOCK  = 8'hD8;
  localparam logic [7:0] OPC_SECTOR = 8'h20;
  localparam logic [7:0] OPC_STATUS = 8'h05;
  localparam logic [7:0] FILLER     = 8'h00;

endpackage

// File: rtl/spi_erase_frame.sv
module spi_erase_frame
  import spi_erase_pkg::*;
(
  input  txn_e              txn,
  input  erase_op_e         op,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        idx,
  output logic [7:0]        tx_byte,
  output logic              last
);

  logic [7:0] erase_opc;
  logic [1:0] final_idx;

  always_comb begin
    case (op)
      OP_BLOCK:  erase_opc = OPC_BLOCK;
      OP_SECTOR: erase_opc = OPC_SECTOR;
      default:   erase_opc = OPC_CHIP;
    endcase
  end

  always_comb begin
    case (txn)
      TX_ERASE: final_idx = (op == OP_CHIP) ? 2'd0 : 2'd3;
      TX_POLL:  final_idx = 2'd1;
      default:  final_idx = 2'd0;
    endcase
  end

  always_comb begin
    tx_byte = FILLER;
    case (txn)
      TX_WREN: tx_byte = OPC_WREN;
      TX_ERASE: begin
        case (idx)
          2'd0:    tx_byte = erase_opc;
          2'd1:    tx_byte = addr[23:16];
          2'd2:    tx_byte = addr[15:8];
          default: tx_byte = addr[7:0];
        endcase
      end
      TX_POLL: tx_byte = (idx == 2'd0) ? OPC_STATUS : FILLER;
      default: tx_byte = FILLER;
    endcase
  end

  assign last = (idx == final_idx);

endmodule

// File: rtl/spi_erase_timer.sv
module spi_erase_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             expire
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (run && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expire = run && (cnt <= CNT_W'(1));

endmodule

// File: rtl/spi_erase_ctrl.sv
module spi_erase_ctrl
  import spi_erase_pkg::*;
#(
  parameter int MAX_POLLS = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx,
  input  logic              last,
  input  logic              expire,
  output txn_e              txn,
  output logic [1:0]        idx,
  output erase_op_e         op_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              tmr_load,
  output logic              tmr_run,
  output logic              spi_start,
  output logic              spi_cs_n,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam int PW = $clog2(MAX_POLLS + 1);

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ISSUE = 3'd1,
    S_XFER  = 3'd2,
    S_GAP   = 3'd3,
    S_WAIT  = 3'd4
  } state_e;

  state_e        state;
  logic [PW-1:0] poll_cnt;
  logic          accept;
  logic          frame_end;
  logic          wip;
  logic          limit_hit;

  assign accept    = (state == S_IDLE) && cmd_start && (erase_op_e'(cmd_op) != OP_RSVD);
  assign frame_end = (state == S_XFER) && spi_done && last;
  assign wip       = spi_rx[0];
  assign limit_hit = (poll_cnt == PW'(MAX_POLLS - 1));

  assign tmr_load  = frame_end && ((txn == TX_ERASE) ||
                                   ((txn == TX_POLL) && wip && !limit_hit));
  assign tmr_run   = (state == S_WAIT);
  assign spi_start = (state == S_ISSUE);
  assign spi_cs_n  = !((state == S_ISSUE) || (state == S_XFER));
  assign busy      = (state != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      txn      <= TX_WREN;
      idx      <= 2'd0;
      op_q     <= OP_CHIP;
      addr_q   <= '0;
      poll_cnt <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            op_q     <= erase_op_e'(cmd_op);
            addr_q   <= cmd_addr;
            txn      <= TX_WREN;
            idx      <= 2'd0;
            poll_cnt <= '0;
            err      <= 1'b0;
            state    <= S_ISSUE;
          end
        end
        S_ISSUE: state <= S_XFER;
        S_XFER: begin
          if (spi_done) begin
            if (!last) begin
              idx   <= idx + 2'd1;
              state <= S_ISSUE;
            end else begin
              idx <= 2'd0;
              case (txn)
                TX_WREN: begin
                  txn   <= TX_ERASE;
                  state <= S_GAP;
                end
                TX_ERASE: begin
                  txn   <= TX_POLL;
                  state <= S_WAIT;
                end
                default: begin
                  if (!wip) begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                  end else if (limit_hit) begin
                    done  <= 1'b1;
                    err   <= 1'b1;
                    state <= S_IDLE;
                  end else begin
                    poll_cnt <= poll_cnt + 1'b1;
                    state    <= S_WAIT;
                  end
                end
              endcase
            end
          end
        end
        S_GAP: state <= S_ISSUE;
        S_WAIT: begin
          if (expire) state <= S_ISSUE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_erase_seq.sv
module spi_erase_seq
  import spi_erase_pkg::*;
#(
  parameter int WAIT_CHIP   = 250_000_000,
  parameter int WAIT_BLOCK  = 25_000_000,
  parameter int WAIT_SECTOR = 2_500_000,
  parameter int MAX_POLLS   = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_start,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic              spi_cs_n,
  output logic              spi_start,
  output logic [7:0]        spi_tx,
  input  logic              spi_done,
  input  logic [7:0]        spi_rx
);

  localparam int WAIT_MAX_CB = (WAIT_CHIP > WAIT_BLOCK) ? WAIT_CHIP : WAIT_BLOCK;
  localparam int WAIT_MAX    = (WAIT_MAX_CB > WAIT_SECTOR) ? WAIT_MAX_CB : WAIT_SECTOR;
  localparam int TW          = $clog2(WAIT_MAX + 1);

  txn_e              txn;
  logic [1:0]        idx;
  erase_op_e         op_q;
  logic [ADDR_W-1:0] addr_q;
  logic              last;
  logic              expire;
  logic              tmr_load;
  logic              tmr_run;
  logic [TW-1:0]     interval;

  always_comb begin
    case (op_q)
      OP_BLOCK:  interval = TW'(WAIT_BLOCK);
      OP_SECTOR: interval = TW'(WAIT_SECTOR);
      default:   interval = TW'(WAIT_CHIP);
    endcase
  end

  spi_erase_ctrl #(.MAX_POLLS(MAX_POLLS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_start (cmd_start),
    .cmd_op    (cmd_op),
    .cmd_addr  (cmd_addr),
    .spi_done  (spi_done),
    .spi_rx    (spi_rx),
    .last      (last),
    .expire    (expire),
    .txn       (txn),
    .idx       (idx),
    .op_q      (op_q),
    .addr_q    (addr_q),
    .tmr_load  (tmr_load),
    .tmr_run   (tmr_run),
    .spi_start (spi_start),
    .spi_cs_n  (spi_cs_n),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  spi_erase_frame u_frame (
    .txn     (txn),
    .op      (op_q),
    .addr    (addr_q),
    .idx     (idx),
    .tx_byte (spi_tx),
    .last    (last)
  );

  spi_erase_timer #(.CNT_W(TW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (interval),
    .run      (tmr_run),
    .expire   (expire)
  );

endmodule

// File: rtl/spi_erase_seq_chk.sv
module spi_erase_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_start,
  input logic [1:0] cmd_op,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       spi_cs_n,
  input logic       spi_start,
  input logic       spi_done
);

  p_start_in_frame_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |-> !spi_cs_n);

  p_start_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    spi_start |=> !spi_start);

  p_cs_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(spi_done));

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_op != 2'd3) |=> busy);

  p_rsvd_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cmd_start && cmd_op == 2'd3) |=> !busy);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);

  p_err_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(err) |-> $past(cmd_start && !busy));

endmodule

bind spi_erase_seq spi_erase_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_start (cmd_start),
  .cmd_op    (cmd_op),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .spi_cs_n  (spi_cs_n),
  .spi_start (spi_start),
  .spi_done  (spi_done)
);

// File: tb/spi_erase_seq_test.sv
module spi_erase_seq_test;

  localparam int WC = 9;
  localparam int WB = 6;
  localparam int WS = 3;
  localparam int MP = 4;
  localparam int LOGN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_start = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [23:0] cmd_addr = '0;
  logic        busy, done, err, spi_cs_n, spi_start;
  logic [7:0]  spi_tx;
  logic        spi_done = 1'b0;
  logic [7:0]  spi_rx = 8'h00;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] log_b [LOGN][4];
  int log_len [LOGN];
  int log_gap [LOGN];
  int ntx = 0;
  int hi_cnt = 0;
  int busy_polls = 0;
  int polls_seen = 0;
  int lat = 0;
  int viol = 0;
  logic cs_prev = 1'b1;
  logic [7:0] rx_next = 8'h00;

  always #2 clk = ~clk;

  spi_erase_seq #(
    .WAIT_CHIP(WC), .WAIT_BLOCK(WB), .WAIT_SECTOR(WS), .MAX_POLLS(MP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .busy(busy), .done(done), .err(err),
    .spi_cs_n(spi_cs_n), .spi_start(spi_start), .spi_tx(spi_tx),
    .spi_done(spi_done), .spi_rx(spi_rx)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Shifter and flash model; observes outputs at the falling edge.
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    spi_done = 1'b0;
    if (rst_n) begin
      if (cs_prev && !spi_cs_n) begin
        if (ntx < LOGN) begin
          log_gap[ntx] = hi_cnt;
          log_len[ntx] = 0;
          ntx++;
        end
        hi_cnt = 0;
      end
      if (spi_cs_n) hi_cnt++;
      if (lat > 0) begin
        lat--;
        if (lat == 0) begin
          spi_done = 1'b1;
          spi_rx   = rx_next;
        end
      end
      if (spi_start) begin
        if (spi_cs_n || lat != 0) viol++;
        lat = 2;
        rx_next = 8'($urandom);
        if (ntx > 0 && log_len[ntx-1] < 4) begin
          if (log_len[ntx-1] == 1 && log_b[ntx-1][0] == 8'h05) begin
            rx_next[0] = (polls_seen < busy_polls);
            polls_seen++;
          end
          log_b[ntx-1][log_len[ntx-1]] = spi_tx;
          log_len[ntx-1]++;
        end
      end
    end
    cs_prev = spi_cs_n;
  end

  function automatic int ival(input logic [1:0] op);
    return (op == 2'd0) ? WC : (op == 2'd1) ? WB : WS;
  endfunction

  function automatic logic [7:0] opc(input logic [1:0] op);
    return (op == 2'd0) ? 8'hC7 : (op == 2'd1) ? 8'hD8 : 8'h20;
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [23:0] a, input int k, input bit inject);
    bit tout;
    int np, g;
    bit ok4, ok6, ok7;
    busy_polls = k;
    polls_seen = 0;
    ntx = 0;
    @(negedge clk);
    cmd_op = op; cmd_addr = a; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    check(busy == 1'b1, "R2 accept", busy, 1);
    check(err == 1'b0, "R9 err cleared by start", err, 0);
    if (inject) begin
      repeat (4) @(negedge clk);
      cmd_op = 2'((op + 1) % 3); cmd_addr = ~a; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
    end
    g = 0;
    while (done !== 1'b1 && g < 5000) begin
      @(negedge clk);
      g++;
    end
    tout = (k >= MP);
    np = tout ? MP : k + 1;
    check(busy == 1'b0, "R8 busy low with done", busy, 0);
    check(err == tout, tout ? "R9 timeout err" : "R8 no err", err, tout);
    check(ntx == 2 + np, inject ? "R10 count after ignored start" : "R8 poll count", ntx, 2 + np);
    check(log_len[0] == 1 && log_b[0][0] == 8'h06, "R3 write enable", log_b[0][0], 8'h06);
    ok4 = (log_b[1][0] == opc(op)) && (log_len[1] == ((op == 2'd0) ? 1 : 4));
    if (op != 2'd0)
      ok4 = ok4 && log_b[1][1] == a[23:16] && log_b[1][2] == a[15:8] && log_b[1][3] == a[7:0];
    check(ok4, inject ? "R10 erase frame after ignored start" : "R4 erase frame",
          {log_b[1][0], log_b[1][1], log_b[1][2], log_b[1][3]},
          {opc(op), a});
    check(log_gap[1] == 1, "R5 gap between write enable and erase", log_gap[1], 1);
    ok6 = 1'b1; ok7 = 1'b1;
    for (int i = 2; i < ntx && i < LOGN; i++) begin
      if (log_len[i] != 2 || log_b[i][0] != 8'h05 || log_b[i][1] != 8'h00) ok6 = 1'b0;
      if (log_gap[i] != ival(op)) ok7 = 1'b0;
    end
    check(ok6, "R6 status frame", log_b[2][0], 8'h05);
    check(ok7, "R7 poll spacing", log_gap[2], ival(op));
    @(negedge clk);
    check(done == 1'b0, "R8 done one cycle", done, 0);
    if (tout) begin
      repeat (3) @(negedge clk);
      check(err == 1'b1, "R9 err held", err, 1);
    end
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && err == 0 && spi_cs_n == 1 && spi_start == 0,
          "R1 reset state", {busy, done, err, spi_cs_n, spi_start}, 5'b00010);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy == 0 && spi_cs_n == 1, "R1 idle after reset", {busy, spi_cs_n}, 2'b01);

    // Reserved code is ignored
    cmd_op = 2'd3; cmd_addr = 24'h123456; cmd_start = 1'b1;
    @(negedge clk);
    cmd_start = 1'b0;
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < 10; i++) begin
        if (busy || !spi_cs_n) stayed = 1'b0;
        @(negedge clk);
      end
      check(stayed && ntx == 0, "R2 reserved code ignored", ntx, 0);
    end

    // Directed cases
    run_op(2'd0, 24'h000000, 0, 0);
    run_op(2'd1, 24'hA5C3F0, 2, 0);
    run_op(2'd2, 24'hFFFFFF, 1, 0);
    run_op(2'd2, 24'h010203, MP - 1, 0);  // last poll clears: no error
    run_op(2'd1, 24'h7E8100, MP + 2, 0);  // timeout
    run_op(2'd0, 24'h000000, 1, 0);       // clears err
    run_op(2'd1, 24'h456789, 2, 1);       // R10 ignored start
    run_op(2'd2, 24'h00FF00, 0, 1);

    // Random cases
    for (int n = 0; n < 10; n++) begin
      run_op(2'($urandom % 3), 24'($urandom), int'($urandom % (MP + 2)), bit'($urandom % 2));
    end

    check(viol == 0, "R11 one byte at a time inside frame", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule